// File: doc/BRIEF.md
# Serial memory command master

This block drives a three-wire serial memory link plus an active-high select line from a parallel request port. A request carries a command (read, write, write-enable or write-disable), a 6-bit address and a 16-bit write word. The block turns the request into a serial frame and generates the serial clock. It shifts the frame out most significant bit first and, for reads, collects the returned word from the serial input. A single-cycle done pulse marks the end of the request.

Every frame starts with a header of nine bits: a start bit of one, a two-bit opcode and a six-bit field. A read adds one discarded turnaround bit and sixteen captured bits. A write adds sixteen data bits. The enable and disable commands are the header alone. A write request can also be wrapped automatically in an enable frame before it and a disable frame after it, as the memory requires.

The serial bit rate comes from a divider input. Each half of a serial clock period lasts `half_div_i + 1` system clocks. Output data changes after a falling serial edge and input data is taken at the rising edge.

Top module: `sermem_master`

## Requirements
- R1: While reset is asserted and right after it, `sclk_o`, `sel_o`, `sdo_o`, `busy_o` and `done_o` are low and `rdata_o` is zero.
- R2: `sclk_o` is low whenever `sel_o` is low. The serial clock only toggles inside a frame.
- R3: Each frame starts with bit 1, then the opcode (read 10, write 01, enable/disable 00), then the six field bits, most significant first. The `cmd_i` encoding is 00 read, 01 write, 10 enable, 11 disable. The rising-edge count per frame is 26 for read, 25 for write and 9 for enable or disable.
- R4: The enable field is 110000 and the disable field is 000000. The four low bits are sent as zeros.
- R5: A read sends the address as its field, then holds `sdo_o` low for 17 more bits. The bit sampled at rise 10 is discarded. Rises 11 to 26 are captured most significant first into `rdata_o`, which keeps that value until the next read completes.
- R6: A write sends the address as its field, followed by the 16 write-data bits, most significant first.
- R7: While `sel_o` stays high, `sdo_o` changes only in the cycle where `sclk_o` falls.
- R8: With H = `half_div_i`+1 system clocks:
  - every high and low serial clock phase lasts exactly H;
  - `sel_o` rises H cycles before the first rising edge;
  - `sel_o` falls H cycles after the last falling edge;
  - `sel_o` stays low for at least H cycles between frames.
- R9: A write with `wrap_i`=1 at acceptance produces three frames in order: enable, write, disable. Every other request produces exactly one frame.
- R10: A request is taken when `req_i` is high and `busy_o` is low. `busy_o` goes high in the next cycle. Requests during busy are ignored. `done_o` is a one-cycle pulse after the last frame, in a cycle where `busy_o` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_div_i | input | 8 | Serial half period minus one, in system clocks; hold stable while busy |
| req_i | input | 1 | Request strobe |
| cmd_i | input | 2 | Command: 00 read, 01 write, 10 enable, 11 disable |
| addr_i | input | 6 | Memory address |
| wdata_i | input | 16 | Word to write |
| wrap_i | input | 1 | Wrap a write in enable and disable frames |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last word read |
| sclk_o | output | 1 | Serial clock |
| sel_o | output | 1 | Active-high device select |
| sdo_o | output | 1 | Serial data to the memory |
| sdi_i | input | 1 | Serial data from the memory |

## Verification
The bench sweeps every command with and without wrapping over four divider settings, and reads all 64 addresses.

The attached memory model drives a one on the turnaround bit. A design that captured that bit would produce a read word shifted by one place. Phase widths, select lead and trail, and inter-frame gaps are measured in system clocks, so an off-by-one divider or a missing hold phase shows up as a wrong count. Frame lengths are checked per command, which catches a read that drops its turnaround bit or a write that sends it.

A stray request issued while busy must produce no extra frame. `rdata_o` is checked after every write and control command to confirm it was left alone.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [1:0] {
    CMD_READ    = 2'b00,
    CMD_WRITE   = 2'b01,
    CMD_ENABLE  = 2'b10,
    CMD_DISABLE = 2'b11
  } cmd_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_CTRL  = 2'b00;

  typedef enum logic [2:0] {
    F_IDLE,
    F_LOW,
    F_HIGH,
    F_HOLD,
    F_GAP
  } fstate_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EN,
    S_MAIN,
    S_DIS
  } sstate_e;

endpackage

// File: rtl/sm_tick_gen.sv
module sm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == half_div_i);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (!run_i || tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R8: the phase counter never runs past the programmed half period
  p_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= half_div_i));

endmodule

// File: rtl/sm_frame_engine.sv
module sm_frame_engine
  import sermem_pkg::*;
#(
  parameter int FRAME_W  = 26,
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 5,
  parameter int RX_FIRST = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               capture_i,
  input  logic               sdi_i,
  output logic               run_o,
  output logic               idle_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               sel_o,
  output logic               sdo_o,
  output logic [DATA_W-1:0]  rdata_o
);

  fstate_e            st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic               cap_q, cap_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic               sclk_q, sel_q, sdo_q;
  logic               sclk_d, sel_d, sdo_d;
  logic               last_bit;

  assign last_bit = (cnt_q == len_q - LEN_W'(1));

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    len_d = len_q;
    cap_d = cap_q;
    rx_d  = rx_q;
    unique case (st_q)
      F_IDLE: if (start_i) begin
        st_d  = F_LOW;
        sh_d  = frame_i;
        cnt_d = '0;
        len_d = len_i;
        cap_d = capture_i;
      end
      F_LOW: if (tick_i) begin
        st_d = F_HIGH;
        if (cap_q && (cnt_q >= LEN_W'(RX_FIRST))) rx_d = {rx_q[DATA_W-2:0], sdi_i};
      end
      F_HIGH: if (tick_i) begin
        if (last_bit) begin
          st_d = F_HOLD;
        end else begin
          st_d  = F_LOW;
          cnt_d = cnt_q + LEN_W'(1);
          sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
        end
      end
      F_HOLD: if (tick_i) st_d = F_GAP;
      F_GAP:  if (tick_i) st_d = F_IDLE;
      default: st_d = F_IDLE;
    endcase
  end

  always_comb begin
    sclk_d = (st_d == F_HIGH);
    sel_d  = (st_d == F_LOW) || (st_d == F_HIGH) || (st_d == F_HOLD);
    sdo_d  = ((st_d == F_LOW) || (st_d == F_HIGH)) ? sh_d[FRAME_W-1] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      cap_q  <= 1'b0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      cap_q  <= cap_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      sel_q  <= sel_d;
      sdo_q  <= sdo_d;
    end
  end

  assign run_o   = (st_q != F_IDLE);
  assign idle_o  = (st_q == F_IDLE);
  assign done_o  = (st_q == F_GAP) && tick_i;
  assign sclk_o  = sclk_q;
  assign sel_o   = sel_q;
  assign sdo_o   = sdo_q;
  assign rdata_o = rx_q;

  // R2: no serial clock pulse outside a selected frame
  p_clk_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |-> !sclk_q);

  // R7: data out moves only with a falling serial clock while selected
  p_sdo_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && $past(sel_q) && !$fell(sclk_q)) |-> $stable(sdo_q));

  // R5: captured read word is untouched while deselected
  p_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |=> $stable(rx_q));

  // R8: select drops only from the hold phase, with the clock already low
  p_sel_trail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_q) |-> ($past(st_q) == F_HOLD) && !$past(sclk_q));

endmodule

// File: rtl/sm_sequencer.sv
module sm_sequencer
  import sermem_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 26,
  parameter int HDR_W   = 9,
  parameter int LEN_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wrap_i,
  input  logic               eng_idle_i,
  input  logic               frame_done_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               capture_o,
  output logic               busy_o,
  output logic               done_o
);

  sstate_e           st_q, st_d;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              wrap_q, wrap_d;
  logic              done_q, done_d;
  logic              wrapped_wr;

  cmd_e              kind;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] field;
  logic [DATA_W:0]   tail;

  assign wrapped_wr = (cmd_q == CMD_WRITE) && wrap_q;

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    wrap_d = wrap_q;
    done_d = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_i) begin
        cmd_d  = cmd_e'(cmd_i);
        addr_d = addr_i;
        wd_d   = wdata_i;
        wrap_d = wrap_i;
        st_d   = ((cmd_e'(cmd_i) == CMD_WRITE) && wrap_i) ? S_EN : S_MAIN;
      end
      S_EN: if (frame_done_i) st_d = S_MAIN;
      S_MAIN: if (frame_done_i) begin
        st_d   = wrapped_wr ? S_DIS : S_IDLE;
        done_d = !wrapped_wr;
      end
      S_DIS: if (frame_done_i) begin
        st_d   = S_IDLE;
        done_d = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cmd_q  <= CMD_READ;
      addr_q <= '0;
      wd_q   <= '0;
      wrap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      wrap_q <= wrap_d;
      done_q <= done_d;
    end
  end

  // frame image for the current step, left aligned
  always_comb begin
    unique case (st_q)
      S_EN:    kind = CMD_ENABLE;
      S_DIS:   kind = CMD_DISABLE;
      default: kind = cmd_q;
    endcase
    opc       = OPC_CTRL;
    field     = addr_q;
    tail      = '0;
    len_o     = LEN_W'(HDR_W);
    capture_o = 1'b0;
    unique case (kind)
      CMD_READ: begin
        opc       = OPC_READ;
        len_o     = LEN_W'(FRAME_W);
        capture_o = 1'b1;
      end
      CMD_WRITE: begin
        opc   = OPC_WRITE;
        tail  = {wd_q, 1'b0};
        len_o = LEN_W'(HDR_W + DATA_W);
      end
      CMD_ENABLE:  field = {2'b11, {(ADDR_W-2){1'b0}}};
      CMD_DISABLE: field = '0;
      default: field = '0;
    endcase
    frame_o = {1'b1, opc, field, tail};
  end

  assign start_o = (st_q != S_IDLE) && eng_idle_i;
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;

  // R10: completion is reported with the block already free
  p_done_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);

  // R10: completion pulse lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R10: busy only rises after a request strobe
  p_busy_from_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  // R9: the disable step only follows the main write step
  p_dis_after_main_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DIS) |-> (($past(st_q) == S_MAIN) || ($past(st_q) == S_DIS)));

endmodule

// File: rtl/sermem_master.sv
module sermem_master
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              sel_o,
  output logic              sdo_o,
  input  logic              sdi_i
);

  localparam int HDR_W   = 1 + 2 + ADDR_W;
  localparam int FRAME_W = HDR_W + 1 + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [1:0]         rst_sync_q;
  logic               rst_n;
  logic               tick, run, eng_idle, frame_done, start, capture;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run),
    .half_div_i (half_div_i),
    .tick_o     (tick)
  );

  sm_sequencer #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .HDR_W   (HDR_W),
    .LEN_W   (LEN_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .req_i        (req_i),
    .cmd_i        (cmd_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .wrap_i       (wrap_i),
    .eng_idle_i   (eng_idle),
    .frame_done_i (frame_done),
    .start_o      (start),
    .frame_o      (frame),
    .len_o        (len),
    .capture_o    (capture),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  sm_frame_engine #(
    .FRAME_W  (FRAME_W),
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .RX_FIRST (HDR_W + 1)
  ) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .start_i   (start),
    .frame_i   (frame),
    .len_i     (len),
    .capture_i (capture),
    .sdi_i     (sdi_i),
    .run_o     (run),
    .idle_o    (eng_idle),
    .done_o    (frame_done),
    .sclk_o    (sclk_o),
    .sel_o     (sel_o),
    .sdo_o     (sdo_o),
    .rdata_o   (rdata_o)
  );

endmodule

// File: tb/sermem_master_test.sv
`timescale 1ns/1ps
module sermem_master_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  half_div;
  logic        req;
  logic [1:0]  cmd;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic        wrap;
  logic        busy, done, sclk, sel, sdo;
  logic        sdi = 1'b0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sermem_master uut (
    .clk_i(clk), .rst_ni(rst_n), .half_div_i(half_div), .req_i(req),
    .cmd_i(cmd), .addr_i(addr), .wdata_i(wdata), .wrap_i(wrap),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .sclk_o(sclk),
    .sel_o(sel), .sdo_o(sdo), .sdi_i(sdi)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [5:0] a);
    return {a, ~a, 4'hA};
  endfunction

  // ---------------- link monitor and memory model ----------------
  int          cyc = 0;
  logic        p_sel = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0, p_done = 1'b0;
  int          t_sel_rise = 0, t_sel_fall = -100000, t_edge = 0, t_last_fall = 0;
  int          nb = 0, lead = 0, wmin = 0, wmax = 0, gap = 0;
  logic [25:0] cur = '0;
  logic [15:0] slave_word = '0;
  bit          r7bad = 0, clkbad = 0, donebad = 0;
  logic [25:0] fr_bits [8];
  int          fr_len [8], fr_lead [8], fr_trail [8], fr_wmin [8], fr_wmax [8], fr_gap [8];
  bit          fr_r7 [8];
  int          fr_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (!sel && sclk) clkbad = 1;
    if (done && p_done) donebad = 1;
    if (sel && !p_sel) begin
      gap = cyc - t_sel_fall; t_sel_rise = cyc; t_edge = cyc;
      nb = 0; cur = '0; wmin = 1000000; wmax = 0; r7bad = 0;
    end
    if (sel && p_sel && (sdo != p_sdo) && !(p_sclk && !sclk)) r7bad = 1;
    if (sel && sclk && !p_sclk) begin
      if (nb == 0) lead = cyc - t_sel_rise;
      else begin
        if (cyc - t_edge < wmin) wmin = cyc - t_edge;
        if (cyc - t_edge > wmax) wmax = cyc - t_edge;
      end
      t_edge = cyc;
      cur = {cur[24:0], sdo};
      nb++;
    end
    if (p_sclk && !sclk) begin
      if (cyc - t_edge < wmin) wmin = cyc - t_edge;
      if (cyc - t_edge > wmax) wmax = cyc - t_edge;
      t_edge = cyc; t_last_fall = cyc;
      if (nb == 9) slave_word = mem_word(cur[5:0]);
      if (nb == 9) sdi = 1'b1;                       // turnaround bit, must be dropped
      else if (nb >= 10 && nb <= 25) sdi = slave_word[25-nb];
      else sdi = 1'b0;
    end
    if (!sel && p_sel) begin
      if (fr_n < 8) begin
        fr_bits[fr_n] = cur; fr_len[fr_n] = nb; fr_lead[fr_n] = lead;
        fr_trail[fr_n] = cyc - t_last_fall; fr_wmin[fr_n] = wmin; fr_wmax[fr_n] = wmax;
        fr_gap[fr_n] = gap; fr_r7[fr_n] = r7bad;
      end
      fr_n++;
      t_sel_fall = cyc;
      sdi = 1'b0;
    end
    p_sel = sel; p_sclk = sclk; p_sdo = sdo; p_done = done;
  end

  // ---------------- expected frames ----------------
  function automatic logic [25:0] exp_bits(input int k, input logic [5:0] a, input logic [15:0] d);
    case (k)
      0: return {1'b1, 2'b10, a, 17'b0};
      1: return {1'b0, 1'b1, 2'b01, a, d};
      2: return {17'b0, 9'b1_00_110000};
      default: return {17'b0, 9'b1_00_000000};
    endcase
  endfunction

  function automatic int exp_len(input int k);
    case (k)
      0: return 26;
      1: return 25;
      default: return 9;
    endcase
  endfunction

  function automatic string kind_req(input int k);
    case (k)
      0: return "R5";
      1: return "R6";
      default: return "R4";
    endcase
  endfunction

  logic [15:0] exp_rd = '0;

  task automatic run_op(input int k, input logic [5:0] a, input logic [15:0] d,
                        input bit wr, input bit stray);
    int h;
    int nexp;
    int kinds [3];
    bit seen;
    h = int'(half_div) + 1;
    fr_n = 0; clkbad = 0; donebad = 0;
    req = 1'b1; cmd = 2'(k); addr = a; wdata = d; wrap = wr;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", longint'(busy), 1);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if (stray && i == 5) begin req = 1'b1; cmd = 2'd0; addr = ~a; end
      if (stray && i == 6) req = 1'b0;
      if (done === 1'b1) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen && busy === 1'b0, "R10 done with busy low", longint'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done single cycle", longint'(done), 0);
    if (stray) repeat (4*h + 4) @(negedge clk);
    if (k == 1 && wr) begin nexp = 3; kinds[0] = 2; kinds[1] = 1; kinds[2] = 3; end
    else begin nexp = 1; kinds[0] = k; end
    chk(fr_n == nexp, "R9 frame count", fr_n, nexp);
    for (int f = 0; f < nexp && f < fr_n; f++) begin
      chk(fr_len[f] == exp_len(kinds[f]), "R3 frame length", fr_len[f], exp_len(kinds[f]));
      chk(fr_bits[f] == exp_bits(kinds[f], a, d), kind_req(kinds[f]),
          fr_bits[f], exp_bits(kinds[f], a, d));
      chk(fr_lead[f] == h, "R8 select lead", fr_lead[f], h);
      chk(fr_trail[f] == h, "R8 select trail", fr_trail[f], h);
      chk(fr_wmin[f] == h && fr_wmax[f] == h, "R8 phase width", fr_wmax[f], h);
      if (f > 0) chk(fr_gap[f] >= h, "R8 gap", fr_gap[f], h);
      chk(!fr_r7[f], "R7 data moved off falling edge", 1, 0);
    end
    chk(!clkbad, "R2 clock outside select", 1, 0);
    chk(!donebad, "R10 done wider than one cycle", 1, 0);
    if (k == 0) exp_rd = mem_word(a);
    chk(rdata == exp_rd, "R5 read word", rdata, exp_rd);
  endtask

  bit finished = 0;

  initial begin
    rst_n = 1'b0; req = 1'b0; cmd = '0; addr = '0; wdata = '0; wrap = 1'b0; half_div = 8'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!sclk && !sel && !sdo && !busy && !done, "R1 outputs in reset",
        {sclk, sel, sdo, busy, done}, 0);
    chk(rdata == 16'h0, "R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sclk && !sel && !busy && !done, "R1 outputs after reset",
        {sclk, sel, busy, done}, 0);

    // sweep divider, command, wrap, two addresses
    for (int hd = 0; hd < 4; hd++) begin
      half_div = 8'(hd);
      for (int k = 0; k < 4; k++)
        for (int w = 0; w < 2; w++)
          for (int ai = 0; ai < 2; ai++)
            run_op(k, ai ? 6'h2D : 6'h12, ai ? 16'hC35A : 16'h8001, w[0], 1'b0);
    end

    // every address read at the fastest rate
    half_div = 8'd0;
    for (int a = 0; a < 64; a++) run_op(0, 6'(a), 16'h0, 1'b0, 1'b0);

    // slower divider, stray requests while busy (R10)
    half_div = 8'd6;
    run_op(1, 6'h3F, 16'hFFFF, 1'b1, 1'b1);
    run_op(0, 6'h21, 16'h0, 1'b0, 1'b1);
    run_op(3, 6'h15, 16'h1234, 1'b1, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule